// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Engine

This block is the bus-facing half of a 1024-byte serial EEPROM that is reached over a two-wire serial bus. It receives the raw clock and data lines, which it oversamples on a faster system clock. It finds start and stop conditions and decodes the device-address byte. It acknowledges by pulling the data line low through an open-drain enable. On writes it loads a word pointer and passes each data byte, with the address it belongs to, to an external write-cycle controller. On reads it fetches bytes from the external array and shifts them out.

The device-address byte has two jobs. Its upper nibble and a strap-compared bit select the chip. Its remaining address bits select one 256-byte block of the array. Write bytes leave on a valid/ready stream. `wr_valid` rises when the eighth bit of a data byte has been sampled. Address and data then stay stable until `wr_ready` is seen high or the serial clock falls to open the acknowledge slot. A byte still unaccepted at that edge is withdrawn and not acknowledged, because the bus clock cannot be held. A stop after accepted bytes raises `wr_commit` so the controller programs them. A repeated start raises `wr_flush` so it drops them. While the controller holds `wr_busy`, the engine acknowledges nothing, so the master can poll until programming ends. `rd_data` must show the byte at `rd_addr` before the next serial clock falling edge after `rd_addr` changes.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A device-address byte whose bits 7:4 differ from binary 1010 is not acknowledged, and the engine leaves the bus released until the next start.
- R2: Bit 3 of the device-address byte must equal `strap_i`, or the byte is not acknowledged.
- R3: Bits 2:1 of an acknowledged device-address byte become address bits 9:8 of the word pointer.
- R4: Bit 0 of the device-address byte picks the direction. 0 is a write: a word-address byte and then data bytes follow. 1 is a read: the engine drives data after its acknowledge.
- R5: In a write, the word-address byte loads pointer bits 7:0 and is acknowledged. Each accepted data byte goes out with the current pointer, and then only pointer bits 3:0 advance, wrapping inside the 16-byte page.
- R6: While `wr_busy` is high at the end of a byte, that byte is not acknowledged, whatever its kind.
- R7: After `wr_busy` falls, a start followed by a matching device address is acknowledged again.
- R8: Read data is shifted out MSB first. After a master acknowledge the pointer advances over all 10 bits (0x3FF wraps to 0x000). A master not-acknowledge ends the read.
- R9: A repeated start after accepted write bytes pulses `wr_flush` for one cycle and does not pulse `wr_commit`.
- R10: A stop after at least one accepted data byte pulses `wr_commit` for one cycle. A stop with no accepted byte pulses nothing.
- R11: A data byte not accepted on the stream by the clock fall that opens its acknowledge slot is not acknowledged. While `wr_valid` waits, `wr_addr` and `wr_data` do not change.
- R12: `sda_oe` is low after reset, and it only asserts while the synchronized serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 1 | Hard-wired chip-select strap compared with address bit 3 |
| wr_busy | input | 1 | Write-cycle controller is programming the array |
| wr_valid | output | 1 | Write byte offered on the stream |
| wr_ready | input | 1 | Controller takes the offered byte |
| wr_addr | output | 10 | Array address of the offered byte |
| wr_data | output | 8 | Offered data byte |
| wr_commit | output | 1 | One-cycle pulse: program the accepted bytes |
| wr_flush | output | 1 | One-cycle pulse: discard the accepted bytes |
| rd_addr | output | 10 | Array address of the next read byte |
| rd_data | input | 8 | Array contents at `rd_addr` |

## Verification
A wrong decode of the device-address nibble, strap bit or busy flag shows at the ninth clock of the same byte, as an acknowledge that should or should not be there. A wrong pointer update does not show on the bus when it happens. It shows in a later read, when a byte comes back from the wrong page slot or the wrong block. Lost commit or flush pulses show on the controller stream in the cycle after the stop or repeated start. They are also visible one transaction later, as data that should or should not have changed, and as an acknowledge pattern that reveals whether programming ever began.

// File: rtl/eeprom_tgt_pkg.sv
package eeprom_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_TXNEXT
  } tgt_state_e;

  typedef enum logic [1:0] {
    RX_DEV,
    RX_WADDR,
    RX_DATA
  } rx_kind_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eeprom_tgt_linesync.sv
module eeprom_tgt_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_tgt_devmatch.sv
module eeprom_tgt_devmatch
  import eeprom_tgt_pkg::*;
#(
  parameter int PSEL_BITS = 2,
  localparam int STRAP_W  = 3 - PSEL_BITS
) (
  input  logic [7:0]           byte_i,
  input  logic [STRAP_W-1:0]   strap_i,
  output logic                 match_o,
  output logic [PSEL_BITS-1:0] psel_o,
  output logic                 rd_o
);
  logic strap_ok;

  generate
    if (STRAP_W > 0) begin : g_strap
      assign strap_ok = (byte_i[3 -: STRAP_W] == strap_i);
    end else begin : g_nostrap
      assign strap_ok = 1'b1;
    end
  endgenerate

  assign match_o = (byte_i[7:4] == DEV_TYPE) && strap_ok;
  assign psel_o  = byte_i[PSEL_BITS:1];
  assign rd_o    = byte_i[0];
endmodule

// File: rtl/eeprom_tgt_ptr.sv
module eeprom_tgt_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic [HI_W-1:0]   hi_val,
  input  logic              ld_lo,
  input  logic [7:0]        lo_val,
  input  logic              inc_page,
  input  logic              inc_lin,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) addr[ADDR_W-1:8] <= hi_val;
      if (ld_lo) addr[7:0]        <= lo_val;
    end else if (inc_page) begin
      addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
    end else if (inc_lin) begin
      addr <= addr + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eeprom_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  localparam int PSEL_BITS  = ADDR_W - 8,
  localparam int STRAP_W    = 3 - PSEL_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [7:0]         wr_data,
  output logic               wr_commit,
  output logic               wr_flush,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [7:0]         rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eeprom_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e st;
  rx_kind_e   kind;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       dir_rd;
  logic       oe_q;
  logic       wr_vld_q;
  logic       acc_q;
  logic       pend_q;
  logic       commit_q;
  logic       flush_q;

  logic                 dev_match, dev_rd;
  logic [PSEL_BITS-1:0] dev_psel;

  eeprom_tgt_devmatch #(.PSEL_BITS(PSEL_BITS)) u_match (
    .byte_i(shreg), .strap_i(strap_i),
    .match_o(dev_match), .psel_o(dev_psel), .rd_o(dev_rd)
  );

  logic byte_done, accept_now, dev_ack, waddr_ack, data_ack, rd_adv;
  logic [ADDR_W-1:0] ptr;

  assign byte_done  = (st == ST_RX) && scl_fall && (cnt == 4'd8);
  assign accept_now = wr_vld_q && wr_ready;
  assign dev_ack    = byte_done && (kind == RX_DEV) && dev_match && !wr_busy;
  assign waddr_ack  = byte_done && (kind == RX_WADDR) && !wr_busy;
  assign data_ack   = byte_done && (kind == RX_DATA) && (acc_q || accept_now) && !wr_busy;
  assign rd_adv     = (st == ST_TXACK) && scl_rise && !sda_s;

  eeprom_tgt_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(dev_ack), .hi_val(dev_psel),
    .ld_lo(waddr_ack), .lo_val(shreg),
    .inc_page(accept_now), .inc_lin(rd_adv),
    .addr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= RX_DEV;
      cnt      <= '0;
      shreg    <= '0;
      dir_rd   <= 1'b0;
      oe_q     <= 1'b0;
      wr_vld_q <= 1'b0;
      acc_q    <= 1'b0;
      pend_q   <= 1'b0;
      commit_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      flush_q  <= 1'b0;
      if (start_det) begin
        st       <= ST_RX;
        kind     <= RX_DEV;
        cnt      <= '0;
        oe_q     <= 1'b0;
        wr_vld_q <= 1'b0;
        acc_q    <= 1'b0;
        flush_q  <= pend_q || accept_now;
        pend_q   <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        oe_q     <= 1'b0;
        wr_vld_q <= 1'b0;
        acc_q    <= 1'b0;
        commit_q <= pend_q || accept_now;
        pend_q   <= 1'b0;
      end else begin
        if (accept_now) begin
          wr_vld_q <= 1'b0;
          acc_q    <= 1'b0;
          pend_q   <= 1'b1;
        end
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
              if (cnt == 4'd7 && kind == RX_DATA) wr_vld_q <= 1'b1;
            end
            if (accept_now && !byte_done) acc_q <= 1'b1;
            if (byte_done) begin
              cnt      <= '0;
              wr_vld_q <= 1'b0;
              acc_q    <= 1'b0;
              if (dev_ack) dir_rd <= dev_rd;
              if (dev_ack || waddr_ack || data_ack) begin
                oe_q <= 1'b1;
                st   <= ST_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == RX_DEV && dir_rd) begin
                shreg <= rd_data;
                oe_q  <= ~rd_data[7];
                st    <= ST_TX;
              end else begin
                oe_q <= 1'b0;
                kind <= (kind == RX_DEV) ? RX_WADDR : RX_DATA;
                st   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                oe_q <= 1'b0;
                st   <= ST_TXACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                oe_q  <= ~shreg[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) st <= sda_s ? ST_IDLE : ST_TXNEXT;
          end
          ST_TXNEXT: begin
            if (scl_fall) begin
              shreg <= rd_data;
              oe_q  <= ~rd_data[7];
              cnt   <= '0;
              st    <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  logic in_ack;
  assign in_ack    = (st == ST_ACK);
  assign sda_oe    = oe_q;
  assign wr_valid  = wr_vld_q;
  assign wr_addr   = ptr;
  assign wr_data   = shreg;
  assign wr_commit = commit_q;
  assign wr_flush  = flush_q;
  assign rd_addr   = ptr;
endmodule

// File: rtl/eeprom_tgt_chk.sv
module eeprom_tgt_chk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              in_ack,
  input logic              dir_rd,
  input logic              wr_busy,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              wr_commit,
  input logic              wr_flush
);
  a_r12_oe_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> !$past(wr_busy));

  a_r11_hold_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ($stable(wr_data) && $stable(wr_addr)));

  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=>
      (wr_addr[ADDR_W-1:PAGE_W] == $past(wr_addr[ADDR_W-1:PAGE_W])));

  a_r4_stream_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !dir_rd);

  a_r9_flush_commit_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_commit, wr_flush}));

  a_r10_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
endmodule

bind eeprom_i2c_target eeprom_tgt_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .in_ack(in_ack),
  .dir_rd(dir_rd), .wr_busy(wr_busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit), .wr_flush(wr_flush)
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;
  localparam int H    = 20;
  localparam int BUSY = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic strap = 1'b0;
  logic ready_en = 1'b1;
  logic wr_valid, wr_commit, wr_flush;
  logic [9:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  int busy_cnt = 0;
  logic wr_busy;

  assign sda_line = sda_m & ~sda_oe;
  assign wr_busy  = (busy_cnt > 0);

  logic [7:0] mem [0:1023];
  logic [7:0] exp_mem [0:1023];
  assign rd_data = mem[rd_addr];

  eeprom_i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .wr_busy(wr_busy), .wr_valid(wr_valid), .wr_ready(ready_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit), .wr_flush(wr_flush),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int nvec = 0, nbad = 0;
  int commits = 0, flushes = 0;
  bit quiet = 0;
  bit done = 0;
  int unsigned qa[$];
  logic [7:0] qd[$];

  // write-cycle controller model: collects, programs on commit, drops on flush
  always @(posedge clk) begin
    if (wr_valid && ready_en) begin
      qa.push_back(int'(wr_addr));
      qd.push_back(wr_data);
    end
    if (wr_flush) begin
      flushes++;
      qa.delete();
      qd.delete();
    end
    if (wr_commit) begin
      commits++;
      foreach (qa[i]) mem[qa[i]] <= qd[i];
      qa.delete();
      qd.delete();
      busy_cnt <= BUSY;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // per-clock comparison: during refused bytes the target must never pull the line
  always @(negedge clk) begin
    if (rst_n && quiet) chk("R6 bus left released", int'(sda_oe), 0);
  end

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b0; hw(H);
    scl_m = 1'b0; hw(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H);
    scl_m = 1'b1; hw(H);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(H);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hw(H);
    scl_m = 1'b1; hw(H / 2);
    acked = (sda_line == 1'b0);
    hw(H / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hw(H);
      scl_m = 1'b1; hw(H / 2);
      b[i] = sda_line;
      hw(H / 2);
      scl_m = 1'b0;
    end
    sda_m = master_ack ? 1'b0 : 1'b1;
    hw(H);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (wr_busy) hw(1);
    hw(4);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] rb;
    int c0, f0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]     = 8'(i * 7 + 3);
      exp_mem[i] = 8'(i * 7 + 3);
    end
    hw(5);
    chk("R12 reset sda_oe", int'(sda_oe), 0);
    chk("R10 reset commit", int'(wr_commit), 0);
    chk("R11 reset wr_valid", int'(wr_valid), 0);
    rst_n = 1'b1;
    hw(5);

    // R1: wrong type nibble
    bus_start();
    quiet = 1; send_byte(8'hB0, ak); quiet = 0;
    chk("R1 type 1011 refused", int'(ak), 0);
    send_byte(8'hA0, ak);
    chk("R1 no ack until next start", int'(ak), 0);
    bus_stop();

    // R2: strap compare
    strap = 1'b1;
    bus_start();
    quiet = 1; send_byte(8'hA4, ak); quiet = 0;
    chk("R2 strap mismatch refused", int'(ak), 0);
    bus_stop();

    // byte write to block 2
    c0 = commits;
    bus_start();
    send_byte(8'hAC, ak); chk("R2 strap match ack", int'(ak), 1);
    send_byte(8'h35, ak); chk("R5 word address ack", int'(ak), 1);
    send_byte(8'h5A, ak); chk("R5 data ack", int'(ak), 1);
    exp_mem[10'h235] = 8'h5A;
    bus_stop();
    hw(4);
    chk("R10 commit after stop", commits - c0, 1);

    // R6 / R7: acknowledge polling
    bus_start();
    quiet = 1; send_byte(8'hAC, ak); quiet = 0;
    chk("R6 busy refuses device address", int'(ak), 0);
    bus_stop();
    wait_idle();
    c0 = commits;
    bus_start();
    send_byte(8'hAC, ak); chk("R7 ack after busy ends", int'(ak), 1);
    bus_stop();
    hw(4);
    chk("R10 no commit without data", commits - c0, 0);

    // R5 / R3: page write with wrap in block 1
    bus_start();
    send_byte(8'hAA, ak); chk("R3 block 1 ack", int'(ak), 1);
    send_byte(8'h2E, ak); chk("R5 word address ack", int'(ak), 1);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'(8'h80 + k), ak);
      chk("R5 page data ack", int'(ak), 1);
      exp_mem[10'h120 + ((14 + k) % 16)] = 8'(8'h80 + k);
    end
    bus_stop();
    wait_idle();

    // R8 / R4: random read crossing a page edge
    bus_start();
    send_byte(8'hAA, ak); chk("R4 write direction ack", int'(ak), 1);
    send_byte(8'h2E, ak); chk("R5 word address ack", int'(ak), 1);
    bus_start();
    send_byte(8'hAB, ak); chk("R4 read direction ack", int'(ak), 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, rb);
      chk("R8 sequential read byte", int'(rb), int'(exp_mem[10'h12E + k]));
    end
    bus_stop();
    for (int k = 0; k < 16; k++) begin
      bus_start();
      send_byte(8'hAA, ak);
      send_byte(8'(8'h20 + k), ak);
      bus_start();
      send_byte(8'hAB, ak);
      recv_byte(1'b0, rb);
      bus_stop();
      chk("R5 page content after wrap", int'(rb), int'(exp_mem[10'h120 + k]));
    end

    // R9: repeated start drops pending bytes
    c0 = commits; f0 = flushes;
    bus_start();
    send_byte(8'hAE, ak);
    send_byte(8'h10, ak);
    send_byte(8'h11, ak); chk("R5 data ack", int'(ak), 1);
    send_byte(8'h22, ak); chk("R5 data ack", int'(ak), 1);
    bus_start();
    send_byte(8'hAF, ak); chk("R9 not busy after discard", int'(ak), 1);
    recv_byte(1'b0, rb);
    chk("R9 pointer read kept old data", int'(rb), int'(exp_mem[10'h312]));
    bus_stop();
    hw(4);
    chk("R9 flush pulse", flushes - f0, 1);
    chk("R9 no commit", commits - c0, 0);
    bus_start();
    send_byte(8'hAE, ak);
    send_byte(8'h10, ak);
    bus_start();
    send_byte(8'hAF, ak);
    recv_byte(1'b0, rb);
    bus_stop();
    chk("R9 discarded byte not programmed", int'(rb), int'(exp_mem[10'h310]));

    // R11: back-pressure refuses the byte
    c0 = commits;
    ready_en = 1'b0;
    bus_start();
    send_byte(8'hA8, ak);
    send_byte(8'h00, ak);
    send_byte(8'h77, ak); chk("R11 unaccepted byte refused", int'(ak), 0);
    bus_stop();
    ready_en = 1'b1;
    hw(4);
    chk("R11 nothing committed", commits - c0, 0);
    chk("R11 controller idle", int'(wr_busy), 0);

    // R8: linear wrap 0x3FF -> 0x000
    bus_start();
    send_byte(8'hAE, ak);
    send_byte(8'hFF, ak);
    bus_start();
    send_byte(8'hAF, ak); chk("R8 read ack", int'(ak), 1);
    recv_byte(1'b1, rb); chk("R8 last byte", int'(rb), int'(exp_mem[10'h3FF]));
    recv_byte(1'b0, rb); chk("R8 wrap to zero", int'(rb), int'(exp_mem[10'h000]));
    bus_stop();
    hw(4);
    chk("R12 bus released at end", int'(sda_oe), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule